// File: doc/BRIEF.md
# Passive Serial Configuration Streamer

This block sits on the host side of a two-wire configuration link that loads a bitstream into one or more target devices. The link has one serial data line and one serial clock line. The targets sample the data line on each rising clock edge. When several targets are cascaded, they share both wires and pass a chip-enable from one to the next. The host therefore sees the chain as a single long target and sends the concatenated bitstream with no addressing.

A configuration run starts with a one-cycle `start_i` request. The block then does the following in order:

1. It pulls the active-low configuration-start output low for a programmable time, then releases it.
2. It waits for the chain's active-low status input to return high.
3. It pulls bytes from a valid/ready stream. It shifts each byte out least-significant bit first, on a clock divided down from the system clock. The data line changes only while the serial clock is low.
4. After the byte marked last, it keeps clocking for a bounded number of extra edges while it waits for the chain's done input.

A status drop or a missing done flag ends the run in an error state. The run ends with done or error. That outcome is held until the next start request or reset.

Top module: `ps_cfg_streamer`

## Requirements
- R1: After reset, `cfg_start_no` is high, `cfg_clk_o` is low, `s_ready_o` is low, and `busy_o`, `done_o` and `error_o` are all low.
- R2: A `start_i` pulse is accepted only when the block is not busy. When accepted, it drives `cfg_start_no` low for exactly `pulse_len_i`+1 system cycles, then high again. A `start_i` pulse while busy produces no second low pulse.
- R3: After `cfg_start_no` is released, no rising edge on `cfg_clk_o` and no `s_ready_o` occur until `status_ni` has been seen high.
- R4: Each byte goes out least-significant bit first, one bit per rising edge of `cfg_clk_o`. The bytes 02 1B EE 01 FA therefore produce, in transmission order, 0100000011011000011101111000000001011111.
- R5: Each high phase of `cfg_clk_o` lasts exactly `div_i`+1 system cycles. Each low phase lasts at least `div_i`+1 system cycles. With `div_i`=0 and a 200 MHz system clock, the serial clock runs at 100 MHz, within the 125 MHz limit.
- R6: `cfg_data_o` changes only while `cfg_clk_o` is low. It holds its value from the system cycle before a rising edge through the whole high phase.
- R7: `s_ready_o` is never high while `cfg_clk_o` is high. It rises only after the eighth rising edge of the current byte and the falling edge that follows it, so every accepted byte yields exactly 8 rising edges. While no byte is available, the clock stays low.
- R8: If `done_i` goes high while bytes or trailing clocks are being sent, the block enters the done state (`done_o`=1). No further rising edges are issued.
- R9: After the byte flagged by `s_last_i`, at most `tmo_len_i` extra rising edges are issued. If `done_i` is still low after them, `error_o` goes high, with exactly `tmo_len_i` extra edges (none when `tmo_len_i`=0).
- R10: If `status_ni` goes low while bytes or trailing clocks are being sent, `error_o` goes high and no further rising edges are issued.
- R11: `done_o` and `error_o` hold, with the serial clock stopped low, until a new `start_i` or reset. A new `start_i` begins a fresh run.
- R12: `busy_o` is high from the cycle after an accepted start until the run ends in done or error, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a configuration run |
| div_i | input | DIV_W | Serial clock half-period minus one, in system cycles |
| pulse_len_i | input | PLS_W | Start pulse length minus one, in system cycles |
| tmo_len_i | input | TMO_W | Extra serial clocks allowed after the last byte |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_ready_o | output | 1 | Byte accepted when high together with s_valid_i |
| cfg_start_no | output | 1 | Active-low configuration start to the chain |
| status_ni | input | 1 | Active-low status from the chain |
| done_i | input | 1 | Configuration done flag from the chain |
| cfg_clk_o | output | 1 | Serial configuration clock |
| cfg_data_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run ended with done seen |
| error_o | output | 1 | Run ended with status drop or timeout |

## Verification
The hardest cases to reach from the ports are those where the chain reacts at one exact serial edge. These are a status drop in the middle of a byte, and a done flag that arrives either on the last data edge or only during the trailing clocks. The bench handles this with a reactive target model. The model counts rising edges of the serial clock and captures the data bit on each one. At a configured edge count it drops the status line or raises done, which places the event at a chosen bit position. The bench sweeps the divider across several values and runs each outcome at every setting. It also inserts idle gaps in the byte stream, so that clock stalls fall at different points of the low phase.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_STREAM,
    ST_TAIL,
    ST_DONE,
    ST_ERR
  } cfg_state_e;
endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             cfg_clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             at_end;

  assign at_end    = (cnt_q >= div_i);
  assign fall_o    = clk_q && at_end;
  assign rise_o    = !clk_q && at_end && run_i;
  assign cfg_clk_o = clk_q;

  // counter saturates at the end of a low phase while no rise is allowed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      if (rise_o || fall_o) cnt_q <= '0;
      else if (!at_end)     cnt_q <= cnt_q + 1'b1;
      if (fall_o)      clk_q <= 1'b0;
      else if (rise_o) clk_q <= 1'b1;
    end
  end

  // R7
  rise_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |-> $past(run_i));
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              fall_i,
  output logic              data_o,
  output logic              empty_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;

  assign data_o  = sh_q[0];
  assign empty_o = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (clear_i) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= byte_i;
      left_q <= CNT_W'(BYTE_W);
    end else if (fall_i && !empty_o) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  // R7
  load_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> left_q == '0);
  // R7
  bits_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q != '0 && !fall_i && !clear_i) |=> $stable(left_q));
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_pkg::*;
#(
  parameter int unsigned PLS_W = 8,
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PLS_W-1:0] pulse_len_i,
  input  logic [TMO_W-1:0] tmo_len_i,
  input  logic             status_ni,
  input  logic             done_i,
  input  logic             empty_i,
  input  logic             accept_i,
  input  logic             last_i,
  input  logic             rise_i,
  output logic             cfg_start_no,
  output logic             stream_o,
  output logic             tail_run_o,
  output logic             last_seen_o,
  output logic             clear_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);
  cfg_state_e       state_q, state_d;
  logic [PLS_W-1:0] pcnt_q;
  logic [TMO_W-1:0] tcnt_q;
  logic             last_q;
  logic             tmo_hit;

  assign tmo_hit = (tcnt_q == tmo_len_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_ERR: if (start_i) state_d = ST_PULSE;
      ST_PULSE:  if (pcnt_q == pulse_len_i) state_d = ST_WAIT;
      ST_WAIT:   if (status_ni) state_d = ST_STREAM;
      ST_STREAM: begin
        if (!status_ni)            state_d = ST_ERR;
        else if (done_i)           state_d = ST_DONE;
        else if (last_q && empty_i) state_d = ST_TAIL;
      end
      ST_TAIL: begin
        if (!status_ni)   state_d = ST_ERR;
        else if (done_i)  state_d = ST_DONE;
        else if (tmo_hit) state_d = ST_ERR;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
      tcnt_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_PULSE) pcnt_q <= '0;
      else                     pcnt_q <= pcnt_q + 1'b1;
      if (state_q != ST_TAIL)  tcnt_q <= '0;
      else if (rise_i)         tcnt_q <= tcnt_q + 1'b1;
      if (state_q == ST_PULSE)           last_q <= 1'b0;
      else if (accept_i && last_i)       last_q <= 1'b1;
    end
  end

  assign cfg_start_no = (state_q != ST_PULSE);
  assign stream_o     = (state_q == ST_STREAM);
  assign tail_run_o   = (state_q == ST_TAIL) && !tmo_hit;
  assign last_seen_o  = last_q;
  assign clear_o      = (state_q == ST_PULSE);
  assign busy_o       = (state_q == ST_PULSE) || (state_q == ST_WAIT) ||
                        (state_q == ST_STREAM) || (state_q == ST_TAIL);
  assign done_o       = (state_q == ST_DONE);
  assign error_o      = (state_q == ST_ERR);

  // R2
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_start_no) |-> $past(start_i));
  // R9 R10
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> ($past(!status_ni) || $past(tmo_hit)));
  // R11
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/ps_cfg_streamer.sv
module ps_cfg_streamer
  import cfg_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PLS_W = 8,
  parameter int unsigned TMO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [PLS_W-1:0]  pulse_len_i,
  input  logic [TMO_W-1:0]  tmo_len_i,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              cfg_start_no,
  input  logic              status_ni,
  input  logic              done_i,
  output logic              cfg_clk_o,
  output logic              cfg_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);
  logic stream, tail_run, last_seen, clear;
  logic empty, rise, fall, run, accept;

  assign s_ready_o = stream && empty && !last_seen;
  assign accept    = s_valid_i && s_ready_o;
  assign run       = (stream && !empty) || tail_run;

  cfg_seq_ctrl #(.PLS_W(PLS_W), .TMO_W(TMO_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pulse_len_i (pulse_len_i),
    .tmo_len_i   (tmo_len_i),
    .status_ni   (status_ni),
    .done_i      (done_i),
    .empty_i     (empty),
    .accept_i    (accept),
    .last_i      (s_last_i),
    .rise_i      (rise),
    .cfg_start_no(cfg_start_no),
    .stream_o    (stream),
    .tail_run_o  (tail_run),
    .last_seen_o (last_seen),
    .clear_o     (clear),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .error_o     (error_o)
  );

  cfg_shifter u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .load_i (accept),
    .byte_i (s_data_i),
    .fall_i (fall),
    .data_o (cfg_data_o),
    .empty_o(empty)
  );

  cfg_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (div_i),
    .run_i    (run),
    .cfg_clk_o(cfg_clk_o),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  // R6
  data_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clk_o |-> $stable(cfg_data_o));
  // R7
  ready_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> !cfg_clk_o);
endmodule

// File: tb/ps_cfg_streamer_tb.sv
module ps_cfg_streamer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] div_i = '0;
  logic [7:0] pulse_len_i = '0;
  logic [7:0] tmo_len_i = '0;
  logic [7:0] s_data_i = '0;
  logic       s_valid_i = 1'b0;
  logic       s_last_i = 1'b0;
  logic       s_ready_o, cfg_start_no, cfg_clk_o, cfg_data_o;
  logic       busy_o, done_o, error_o;
  logic       status_ni = 1'b1;
  logic       done_i = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ps_cfg_streamer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .div_i(div_i),
    .pulse_len_i(pulse_len_i), .tmo_len_i(tmo_len_i), .s_data_i(s_data_i),
    .s_valid_i(s_valid_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
    .cfg_start_no(cfg_start_no), .status_ni(status_ni), .done_i(done_i),
    .cfg_clk_o(cfg_clk_o), .cfg_data_o(cfg_data_o), .busy_o(busy_o),
    .done_o(done_o), .error_o(error_o)
  );

  localparam logic [39:0] WIRE_EX = 40'b0100000011011000011101111000000001011111;

  int cmp_cnt = 0, mis_cnt = 0;
  int m_div = 0, m_done_after = -1, m_fail_at = -1, m_stat_dly = 4;
  int rises = 0, hi_len = 0, lo_len = 1000, hi_bad = 0, lo_bad = 0, data_bad = 0;
  int rdy_bad = 0, pre_bad = 0, acc_cnt = 0, rises_at_acc = 0;
  int pulse_cnt = 0, start_lo_len = 0, last_pulse_len = 0, stat_cnt = 0;
  bit stat_pending = 0, prev_clk = 0, prev_start = 1, prev_data = 0;
  bit cap [0:1023];

  task automatic chk(bit ok, string req, int act, int exp);
    cmp_cnt++;
    if (!ok) begin
      mis_cnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(int pat, int k);
    logic [7:0] ex [0:4];
    ex[0] = 8'h02; ex[1] = 8'h1B; ex[2] = 8'hEE; ex[3] = 8'h01; ex[4] = 8'hFA;
    if (pat == 0) return ex[k];
    return 8'(k * 53 + pat * 29 + 7);
  endfunction

  // target chain model and line monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!cfg_start_no) begin
        if (prev_start) begin
          start_lo_len = 1; pulse_cnt++; stat_pending = 1; stat_cnt = 0;
        end else start_lo_len++;
        status_ni = 1'b0;
      end else begin
        if (!prev_start) last_pulse_len = start_lo_len;
        if (stat_pending) begin
          stat_cnt++;
          if (stat_cnt >= m_stat_dly) begin status_ni = 1'b1; stat_pending = 0; end
        end
      end
      if (stat_pending && (s_ready_o || cfg_clk_o)) pre_bad++;
      if (cfg_clk_o && !prev_clk) begin
        if (lo_len < m_div + 1) lo_bad++;
        if (rises < 1024) cap[rises] = cfg_data_o;
        rises++;
        hi_len = 1;
      end else if (cfg_clk_o) hi_len++;
      if (!cfg_clk_o && prev_clk) begin
        if (hi_len != m_div + 1) hi_bad++;
        lo_len = 1;
      end else if (!cfg_clk_o) lo_len++;
      if (cfg_clk_o && cfg_data_o != prev_data) data_bad++;
      if (s_ready_o && cfg_clk_o) rdy_bad++;
      if (s_ready_o && s_valid_i) begin
        if (acc_cnt > 0 && rises - rises_at_acc != 8) rdy_bad++;
        acc_cnt++;
        rises_at_acc = rises;
      end
      if (m_fail_at >= 0 && rises >= m_fail_at) status_ni = 1'b0;
      done_i = (m_done_after >= 0 && rises >= m_done_after);
      prev_clk = cfg_clk_o; prev_start = cfg_start_no; prev_data = cfg_data_o;
    end
  end

  task automatic pulse_start();
    @(posedge clk_i); #1 start_i = 1'b1;
    @(posedge clk_i); #1 start_i = 1'b0;
  endtask

  task automatic send_stream(int n, int gap, int pat);
    bit stop = 0;
    for (int k = 0; k < n; k++) begin
      if (stop) break;
      repeat (gap) @(posedge clk_i);
      @(posedge clk_i); #1;
      s_data_i = byte_of(pat, k); s_valid_i = 1'b1; s_last_i = (k == n - 1);
      forever begin
        @(negedge clk_i);
        if (s_ready_o) begin @(posedge clk_i); #1; break; end
        if (done_o || error_o) begin stop = 1; break; end
      end
      s_valid_i = 1'b0; s_last_i = 1'b0;
    end
  endtask

  task automatic run_case(int d, int plen, int tmo, int n, int gap, int pat,
                          int done_after, int fail_at, bit extra);
    int bit_err = 0;
    int nbits;
    int snap;
    bit fin;
    @(posedge clk_i); #1;
    div_i = 8'(d); pulse_len_i = 8'(plen); tmo_len_i = 8'(tmo);
    m_div = d; m_done_after = done_after; m_fail_at = fail_at; m_stat_dly = 4 + d;
    rises = 0; hi_bad = 0; lo_bad = 0; data_bad = 0; rdy_bad = 0; pre_bad = 0;
    acc_cnt = 0; rises_at_acc = 0; pulse_cnt = 0; last_pulse_len = 0; lo_len = 1000;
    done_i = 1'b0;
    pulse_start();
    @(negedge clk_i);
    chk(busy_o == 1'b1 && !done_o && !error_o, "R12 busy after start", int'(busy_o), 1);
    fork
      send_stream(n, gap, pat);
      begin
        if (extra) begin
          wait (rises >= 4);
          pulse_start();
        end
      end
    join
    while (!(done_o || error_o)) @(negedge clk_i);
    repeat (4 * (d + 1) + 8) @(negedge clk_i);

    chk(last_pulse_len == plen + 1, "R2 start pulse length", last_pulse_len, plen + 1);
    chk(pulse_cnt == 1, "R2 start ignored while busy", pulse_cnt, 1);
    chk(pre_bad == 0, "R3 no activity before status high", pre_bad, 0);
    chk(hi_bad == 0, "R5 high phase length", hi_bad, 0);
    chk(lo_bad == 0, "R5 low phase length", lo_bad, 0);
    chk(data_bad == 0, "R6 data stable at rise and high", data_bad, 0);
    chk(rdy_bad == 0, "R7 ready timing", rdy_bad, 0);

    nbits = (fail_at >= 0) ? fail_at : 8 * n;
    for (int i = 0; i < nbits; i++)
      if (cap[i] != byte_of(pat, i / 8)[i % 8]) bit_err++;
    chk(bit_err == 0, "R4 lsb-first bits", bit_err, 0);
    if (pat == 0 && n == 5) begin
      bit_err = 0;
      for (int i = 0; i < 40; i++)
        if (cap[i] != WIRE_EX[39 - i]) bit_err++;
      chk(bit_err == 0, "R4 example wire pattern", bit_err, 0);
    end

    if (fail_at >= 0) begin
      chk(error_o && !done_o, "R10 error on status drop", int'(error_o), 1);
      chk(rises == fail_at, "R10 clock stops after status drop", rises, fail_at);
    end else if (done_after >= 0) begin
      chk(done_o && !error_o, "R8 done seen", int'(done_o), 1);
      chk(rises == done_after, "R8 no rises after done", rises, done_after);
      chk(acc_cnt == n, "R7 bytes accepted", acc_cnt, n);
    end else begin
      chk(error_o && !done_o, "R9 timeout error", int'(error_o), 1);
      chk(rises == 8 * n + tmo, "R9 extra clock count", rises, 8 * n + tmo);
      chk(acc_cnt == n, "R7 bytes accepted", acc_cnt, n);
    end
    chk(!busy_o, "R12 busy cleared at end", int'(busy_o), 0);

    fin = done_o;
    snap = rises;
    repeat (40) @(negedge clk_i);
    chk(done_o == fin && error_o == !fin && rises == snap && !cfg_clk_o,
        "R11 outcome held", rises, snap);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    cmp_cnt++; mis_cnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, mis_cnt);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(cfg_start_no == 1'b1, "R1 start line idle high", int'(cfg_start_no), 1);
    chk(cfg_clk_o == 1'b0, "R1 clock low", int'(cfg_clk_o), 0);
    chk(s_ready_o == 1'b0, "R1 ready low", int'(s_ready_o), 0);
    chk({busy_o, done_o, error_o} == 3'b000, "R1 flags low",
        int'({busy_o, done_o, error_o}), 0);
    for (int d = 0; d < 4; d++) begin
      run_case(d, d + 1, 4, 5, 0, 0, 40, -1, 0);
      run_case(d, 2 * d, 5, 6, 3, d + 1, 50, -1, 1);
      run_case(d, 0, 3, 2, 1, d + 2, -1, -1, 0);
      run_case(d, 3, 0, 3, 0, d + 3, -1, -1, 0);
      run_case(d, 1, 6, 4, 2, d + 4, -1, 10 + 3 * d, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, mis_cnt);
    $finish;
  end
endmodule